// File: doc/BRIEF.md
# Processor I/O Port with Decaying Floating Bits

This block is the on-chip 8-bit I/O port of a small processor, mapped at two bus addresses: a direction register (1 = output) at address 0 and an output data register at address 1. It keeps the state of the eight port pins and derives a 3-bit memory-configuration code for the banking logic next to it. Any access to another address is passed straight through to the backing RAM. Writes to the two port addresses also reach the RAM, but carry the last byte seen on the data bus instead of the written value.

Bits 6 and 7 have no pin behind them. When one of them is switched to input it behaves like a floating node that holds a charge. Writing it while it is an output, or switching it from output to input, stores a level and starts a timer. Once the timer expires, reading address 1 returns 0 for that bit. The timeout is a parameter counted against an externally supplied free-running cycle count, so test software that expects a short fall-off can be matched.

Reads have one cycle of latency. The request is sampled on a clock edge and `bus_rdata` is valid after that edge.

Top module: `cpu_io_port`

## Requirements
- R1: After synchronous reset the direction register is 0x00, the data register and pin state are 0x3F, `cfg_out` is 3'b111, both floating bits hold 0 with no timer running, and a read of address 1 returns 0x1F.
- R2: A read of address 0 returns the direction register. A read of any address other than 0 or 1 returns `ram_rdata`. Both are valid on `bus_rdata` one cycle after the request.
- R3: After every register write, `pin_out` = (old pins AND NOT dir) OR (data AND dir), computed with the new register values. Without a register write, `pin_out` does not change.
- R4: The base read value of address 1 is (data OR NOT dir) AND (pins OR 0x17). Bit 5 of it is forced to 0 whenever direction bit 5 is 0.
- R5: `cfg_out` always equals bits 2..0 of (data OR NOT dir).
- R6: A write to address 1 makes each of bits 6 and 7 whose direction bit is 1 take the written bit, with a deadline of cycle + FALL_CYCLES. If that bit's timer is already running, it restarts.
- R7: A write to address 0 that turns direction bit 6 or 7 from 1 to 0 makes that bit take the current data-register bit, with a fresh deadline of cycle + FALL_CYCLES.
- R8: In a read of address 1, each of bits 6 and 7 whose direction bit is 0 returns its held level instead of the base value.
- R9: A held level expires only when its deadline is strictly less than `cycle_now` at the read of address 1. The read that finds the expiry returns 0 and clears the held level. A read with `cycle_now` equal to the deadline still returns the held level.
- R10: Every bus write is forwarded to the RAM at the same address. For addresses 0 and 1 the RAM data is `last_bus_byte`; for all other addresses it is `bus_wdata`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Access address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid one cycle after the request |
| last_bus_byte | input | 8 | Last byte seen on the data bus |
| cycle_now | input | CNT_W | Free-running cycle count |
| ram_we | output | 1 | Write enable to the backing RAM |
| ram_addr | output | ADDR_W | Address to the backing RAM |
| ram_wdata | output | 8 | Write data to the backing RAM |
| ram_rdata | input | 8 | Synchronous read data from the backing RAM |
| pin_out | output | 8 | Port pin state |
| cfg_out | output | 3 | Memory-configuration code |

## Verification
The bound assertions check on every cycle:
- that `cfg_out` and the driven pins follow the registers;
- that the pins hold still when no register is written;
- the reset values;
- the RAM write-data substitution;
- the direction-register readback.

The decay of bits 6 and 7 depends on event history and on the cycle count, so only the bench's scenarios can show it:
- a charge read back before the deadline;
- the exact deadline boundary;
- the drop to 0 after it;
- a timer restart by a rewrite.

Random register traffic is then compared against a bench model of the port.

// File: rtl/cpu_port_pkg.sv
package cpu_port_pkg;
  localparam int PORT_W    = 8;
  localparam int CFG_W     = 3;
  localparam int FLOAT_LO  = 6;
  localparam int NUM_FLOAT = 2;
  localparam int SENSE_BIT = 5;

  localparam logic [PORT_W-1:0] PIN_RD_MASK = 8'h17;
  localparam logic [PORT_W-1:0] RST_DIR     = 8'h00;
  localparam logic [PORT_W-1:0] RST_DATA    = 8'h3F;
  localparam logic [PORT_W-1:0] RST_PINS    = 8'h3F;

  typedef enum logic [1:0] {
    SRC_DIR  = 2'd0,
    SRC_PORT = 2'd1,
    SRC_RAM  = 2'd2
  } rd_src_e;
endpackage

// File: rtl/cpu_port_regs.sv
module cpu_port_regs
  import cpu_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              dir_wr,
  input  logic              data_wr,
  input  logic [PORT_W-1:0] wdata,
  output logic [PORT_W-1:0] dir_q,
  output logic [PORT_W-1:0] data_q,
  output logic [PORT_W-1:0] pins_q,
  output logic [CFG_W-1:0]  cfg_q,
  output logic [PORT_W-1:0] base_rd
);
  logic [PORT_W-1:0] dir_n, data_n, pins_n, drive_n;
  logic [CFG_W-1:0]  cfg_n;

  always_comb begin
    dir_n   = dir_wr  ? wdata : dir_q;
    data_n  = data_wr ? wdata : data_q;
    pins_n  = (pins_q & ~dir_n) | (data_n & dir_n);
    drive_n = data_n | ~dir_n;
    cfg_n   = drive_n[CFG_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q  <= RST_DIR;
      data_q <= RST_DATA;
      pins_q <= RST_PINS;
      cfg_q  <= '1;
    end else if (dir_wr || data_wr) begin
      dir_q  <= dir_n;
      data_q <= data_n;
      pins_q <= pins_n;
      cfg_q  <= cfg_n;
    end
  end

  always_comb begin
    base_rd = (data_q | ~dir_q) & (pins_q | PIN_RD_MASK);
    if (!dir_q[SENSE_BIT]) base_rd[SENSE_BIT] = 1'b0;
  end
endmodule

// File: rtl/cpu_port_decay_cell.sv
module cpu_port_decay_cell #(
  parameter int CNT_W       = 32,
  parameter int FALL_CYCLES = 350000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dir_bit,
  input  logic             dir_wr,
  input  logic             dir_new_bit,
  input  logic             data_wr,
  input  logic             data_new_bit,
  input  logic             data_cur_bit,
  input  logic             rd_port,
  input  logic [CNT_W-1:0] cycle_now,
  output logic             held_eff
);
  localparam logic [CNT_W-1:0] FALL_V = CNT_W'(FALL_CYCLES);

  logic             level_q;
  logic             armed_q;
  logic [CNT_W-1:0] deadline_q;
  logic             expired;
  logic             charge_data, charge_dir;

  always_comb begin
    expired     = armed_q && (deadline_q < cycle_now);
    held_eff    = expired ? 1'b0 : level_q;
    charge_data = data_wr && dir_bit;
    charge_dir  = dir_wr && dir_bit && !dir_new_bit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      level_q    <= 1'b0;
      armed_q    <= 1'b0;
      deadline_q <= '0;
    end else if (charge_data) begin
      level_q    <= data_new_bit;
      armed_q    <= 1'b1;
      deadline_q <= cycle_now + FALL_V;
    end else if (charge_dir) begin
      level_q    <= data_cur_bit;
      armed_q    <= 1'b1;
      deadline_q <= cycle_now + FALL_V;
    end else if (rd_port && expired) begin
      level_q <= 1'b0;
      armed_q <= 1'b0;
    end
  end
endmodule

// File: rtl/cpu_port_bus.sv
module cpu_port_bus
  import cpu_port_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DIR_ADDR  = 0,
  parameter int DATA_ADDR = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [PORT_W-1:0] bus_wdata,
  input  logic [PORT_W-1:0] last_bus_byte,
  input  logic [PORT_W-1:0] dir_q,
  input  logic [PORT_W-1:0] port_val,
  input  logic [PORT_W-1:0] ram_rdata,
  output logic              dir_wr,
  output logic              data_wr,
  output logic              rd_port,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [PORT_W-1:0] ram_wdata,
  output logic [PORT_W-1:0] bus_rdata
);
  localparam logic [ADDR_W-1:0] DIR_A  = ADDR_W'(DIR_ADDR);
  localparam logic [ADDR_W-1:0] DATA_A = ADDR_W'(DATA_ADDR);

  logic              hit_dir, hit_data, rd_req;
  rd_src_e           src_q;
  logic [PORT_W-1:0] loc_q;

  always_comb begin
    hit_dir   = (bus_addr == DIR_A);
    hit_data  = (bus_addr == DATA_A);
    rd_req    = bus_sel && !bus_we;
    dir_wr    = bus_sel && bus_we && hit_dir;
    data_wr   = bus_sel && bus_we && hit_data;
    rd_port   = rd_req && hit_data;
    ram_we    = bus_sel && bus_we;
    ram_addr  = bus_addr;
    ram_wdata = (hit_dir || hit_data) ? last_bus_byte : bus_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q <= SRC_DIR;
      loc_q <= '0;
    end else if (rd_req) begin
      if (hit_dir) begin
        src_q <= SRC_DIR;
        loc_q <= dir_q;
      end else if (hit_data) begin
        src_q <= SRC_PORT;
        loc_q <= port_val;
      end else begin
        src_q <= SRC_RAM;
      end
    end
  end

  assign bus_rdata = (src_q == SRC_RAM) ? ram_rdata : loc_q;
endmodule

// File: rtl/cpu_io_port.sv
module cpu_io_port
  import cpu_port_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int CNT_W       = 32,
  parameter int FALL_CYCLES = 350000,
  parameter int DIR_ADDR    = 0,
  parameter int DATA_ADDR   = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic [7:0]        last_bus_byte,
  input  logic [CNT_W-1:0]  cycle_now,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [7:0]        ram_wdata,
  input  logic [7:0]        ram_rdata,
  output logic [7:0]        pin_out,
  output logic [2:0]        cfg_out
);
  logic              dir_wr, data_wr, rd_port;
  logic [PORT_W-1:0] dir_q, data_q, pins_q, base_rd, port_val;
  logic [NUM_FLOAT-1:0] held_eff;

  cpu_port_bus #(
    .ADDR_W(ADDR_W), .DIR_ADDR(DIR_ADDR), .DATA_ADDR(DATA_ADDR)
  ) u_bus (
    .clk(clk), .rst(rst),
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .last_bus_byte(last_bus_byte),
    .dir_q(dir_q), .port_val(port_val), .ram_rdata(ram_rdata),
    .dir_wr(dir_wr), .data_wr(data_wr), .rd_port(rd_port),
    .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .bus_rdata(bus_rdata)
  );

  cpu_port_regs u_regs (
    .clk(clk), .rst(rst),
    .dir_wr(dir_wr), .data_wr(data_wr), .wdata(bus_wdata),
    .dir_q(dir_q), .data_q(data_q), .pins_q(pins_q),
    .cfg_q(cfg_out), .base_rd(base_rd)
  );

  for (genvar k = 0; k < NUM_FLOAT; k++) begin : g_float
    localparam int B = FLOAT_LO + k;
    cpu_port_decay_cell #(
      .CNT_W(CNT_W), .FALL_CYCLES(FALL_CYCLES)
    ) u_cell (
      .clk(clk), .rst(rst),
      .dir_bit(dir_q[B]), .dir_wr(dir_wr), .dir_new_bit(bus_wdata[B]),
      .data_wr(data_wr), .data_new_bit(bus_wdata[B]),
      .data_cur_bit(data_q[B]), .rd_port(rd_port),
      .cycle_now(cycle_now), .held_eff(held_eff[k])
    );
  end

  always_comb begin
    port_val = base_rd;
    for (int k = 0; k < NUM_FLOAT; k++) begin
      if (!dir_q[FLOAT_LO+k]) port_val[FLOAT_LO+k] = held_eff[k];
    end
  end

  assign pin_out = pins_q;
endmodule

// File: rtl/cpu_io_port_chk.sv
module cpu_io_port_chk #(
  parameter int ADDR_W    = 16,
  parameter int DIR_ADDR  = 0,
  parameter int DATA_ADDR = 1
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [7:0]        bus_rdata,
  input logic [7:0]        last_bus_byte,
  input logic              ram_we,
  input logic [ADDR_W-1:0] ram_addr,
  input logic [7:0]        ram_wdata,
  input logic [7:0]        pin_out,
  input logic [2:0]        cfg_out,
  input logic [7:0]        dir_q,
  input logic [7:0]        data_q,
  input logic              dir_wr,
  input logic              data_wr
);
  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cfg_out == 3'b111 && pin_out == 8'h3F && dir_q == 8'h00));

  assert_cfg_follows_R5: assert property (@(posedge clk) disable iff (rst)
    cfg_out == (data_q[2:0] | ~dir_q[2:0]));

  assert_driven_pins_R3: assert property (@(posedge clk) disable iff (rst)
    (pin_out & dir_q) == (data_q & dir_q));

  assert_pins_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !$past(dir_wr || data_wr) |-> $stable(pin_out));

  assert_ram_subst_R10: assert property (@(posedge clk) disable iff (rst)
    (ram_we && (ram_addr == ADDR_W'(DIR_ADDR) || ram_addr == ADDR_W'(DATA_ADDR)))
      |-> ram_wdata == last_bus_byte);

  assert_dir_readback_R2: assert property (@(posedge clk) disable iff (rst)
    $past(bus_sel && !bus_we && bus_addr == ADDR_W'(DIR_ADDR))
      |-> bus_rdata == $past(dir_q));
endmodule

bind cpu_io_port cpu_io_port_chk #(
  .ADDR_W(ADDR_W), .DIR_ADDR(DIR_ADDR), .DATA_ADDR(DATA_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .last_bus_byte(last_bus_byte),
  .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
  .pin_out(pin_out), .cfg_out(cfg_out), .dir_q(dir_q), .data_q(data_q),
  .dir_wr(dir_wr), .data_wr(data_wr)
);

// File: tb/tb_cpu_io_port.sv
`timescale 1ns/1ps
module tb_cpu_io_port;
  localparam int AW   = 8;
  localparam int FALL = 40;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_sel = 1'b0, bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [7:0]    bus_wdata = '0, last_bus_byte = '0;
  logic [7:0]    bus_rdata, ram_wdata, pin_out;
  logic [7:0]    ram_rdata = '0;
  logic [31:0]   cyc = '0;
  logic          ram_we;
  logic [AW-1:0] ram_addr;
  logic [2:0]    cfg_out;

  int n_vec = 0, n_bad = 0;
  bit done = 0;

  logic [7:0] mem [256];
  logic [7:0] shadow [256];

  // bench model
  logic [7:0]  m_dir, m_data, m_pins;
  logic [1:0]  m_lvl, m_arm;
  logic [31:0] m_dl [2];

  cpu_io_port #(.ADDR_W(AW), .CNT_W(32), .FALL_CYCLES(FALL)) dut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .last_bus_byte(last_bus_byte), .cycle_now(cyc),
    .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .ram_rdata(ram_rdata), .pin_out(pin_out), .cfg_out(cfg_out)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= rst ? 32'd0 : cyc + 32'd1;
    if (ram_we) mem[ram_addr] <= ram_wdata;
    ram_rdata <= mem[ram_addr];
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic logic [7:0] exp_base();
    logic [7:0] v;
    v = (m_data | ~m_dir) & (m_pins | 8'h17);
    if (!m_dir[5]) v[5] = 1'b0;
    return v;
  endfunction

  task automatic do_write(input logic [7:0] a, input logic [7:0] v);
    logic [7:0] lb;
    lb = 8'($urandom);
    for (int k = 0; k < 2; k++) begin
      if (a == 8'd1 && m_dir[6+k]) begin
        m_lvl[k] = v[6+k]; m_arm[k] = 1'b1; m_dl[k] = cyc + FALL;
      end
      if (a == 8'd0 && m_dir[6+k] && !v[6+k]) begin
        m_lvl[k] = m_data[6+k]; m_arm[k] = 1'b1; m_dl[k] = cyc + FALL;
      end
    end
    if (a == 8'd0) m_dir = v;
    if (a == 8'd1) m_data = v;
    if (a <= 8'd1) m_pins = (m_pins & ~m_dir) | (m_data & m_dir);
    shadow[a] = (a <= 8'd1) ? lb : v;
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = v; last_bus_byte = lb;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
    check("R3 pins", pin_out, m_pins);
    check("R5 cfg", {5'b0, cfg_out}, {5'b0, m_data[2:0] | ~m_dir[2:0]});
    if (a <= 8'd1) check("R10 ram gets last bus byte", mem[a], lb);
  endtask

  task automatic do_read(input logic [7:0] a, input string req);
    logic [7:0] e;
    if (a == 8'd0) e = m_dir;
    else if (a == 8'd1) begin
      for (int k = 0; k < 2; k++)
        if (m_arm[k] && m_dl[k] < cyc) begin m_arm[k] = 1'b0; m_lvl[k] = 1'b0; end
      e = exp_base();
      for (int k = 0; k < 2; k++) if (!m_dir[6+k]) e[6+k] = m_lvl[k];
    end else e = shadow[a];
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    check(req, bus_rdata, e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_cyc(input logic [31:0] t);
    while (cyc < t) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240));
    for (int i = 0; i < 256; i++) begin mem[i] = 8'h00; shadow[i] = 8'h00; end
    m_dir = 8'h00; m_data = 8'h3F; m_pins = 8'h3F; m_lvl = '0; m_arm = '0;
    m_dl[0] = '0; m_dl[1] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset values
    check("R1 pins", pin_out, 8'h3F);
    check("R1 cfg", {5'b0, cfg_out}, 8'h07);
    do_read(8'd1, "R1 port read 1F");
    do_read(8'd0, "R1 dir read 00");

    // R4: bit 5 as output follows data; R2 ram pass-through
    do_write(8'd0, 8'h20);
    do_read(8'd1, "R4 base with dir5 output");
    do_write(8'd9, 8'hA5);
    do_read(8'd9, "R2 ram pass-through");

    // R6/R7/R8: charge, then switch to input
    do_write(8'd0, 8'hC0);
    do_write(8'd1, 8'hC0);
    do_write(8'd0, 8'h00);
    do_read(8'd1, "R8 charge held before deadline");
    wait_cyc(m_dl[0]);
    do_read(8'd1, "R9 still held at deadline");
    do_read(8'd1, "R9 expired after deadline");
    do_read(8'd1, "R9 stays cleared");

    // R6 restart: rewrite before deadline
    do_write(8'd0, 8'hC0);
    do_write(8'd1, 8'hC0);
    do_write(8'd0, 8'h00);
    idle(30);
    do_write(8'd0, 8'hC0);
    do_write(8'd1, 8'h80);
    do_write(8'd0, 8'h00);
    idle(20);
    do_read(8'd1, "R6 restarted timer keeps bit7, bit6 rewritten 0");

    // R7: dir drop latches current data bit 0
    do_write(8'd0, 8'h40);
    do_write(8'd1, 8'h00);
    do_write(8'd0, 8'h00);
    do_read(8'd1, "R7 dir drop latches data 0");

    // constrained random
    for (int it = 0; it < 400; it++) begin
      int op;
      logic [7:0] v;
      op = int'($urandom_range(0, 5));
      case ($urandom_range(0, 3))
        0: v = 8'hC0;
        1: v = 8'h00;
        2: v = {2'($urandom), 6'h00};
        default: v = 8'($urandom);
      endcase
      case (op)
        0: do_write(8'd0, v);
        1: do_write(8'd1, 8'($urandom));
        2: do_read(8'd1, "R4/R8/R9 random port read");
        3: do_read(8'd0, "R2 random dir read");
        4: begin
          logic [7:0] a;
          a = 8'($urandom_range(2, 255));
          do_write(a, 8'($urandom));
          do_read(a, "R2/R10 random ram");
        end
        default: idle(int'($urandom_range(0, 30)));
      endcase
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule